// File: doc/BRIEF.md
# Multiplexed Bus Slave with Wait-State Ready

This block sits on the peripheral side of a 16-bit multiplexed address/data bus driven by a host. The host first puts an address on the shared lines and pulses an address strobe. It then lowers a read or a write strobe while the block's chip select is low. All the strobes are active low. Behind the bus interface is a generic bank of 32-bit registers. The bus reaches each register as two 16-bit halves.

The block holds the host in wait states through a ready output. Ready falls on the first falling bus-clock edge after a strobe arrives. It stays low for a parameterised number of cycles and is released on a rising bus-clock edge. On a read, valid data appears at the moment ready is released. On a write, the data is taken into a holding register as soon as the wait begins, and it reaches the addressed half only when the wait ends. The shared data lines are brought out as separate input, output and output-enable signals so that the pad ring can build the tri-state buffer.

Top module: `mbs_slave`

## Requirements
- R1: The address in use is `ad_i[10:0]` as sampled at the last falling clock edge at which `ale` was high. Bits 15:11 of the shared lines are ignored.
- R2: Address bits 10:2 select the register. Address bit 1 selects the half: 1 means bits 31:16 and 0 means bits 15:0. Address bit 0 has no effect.
- R3: After a read or write strobe goes low with `cs_n` low, `ready_o` stays high until the first falling clock edge. At that edge it goes low.
- R4: For each access, `ready_o` is seen low at exactly `WAIT_CYCLES` consecutive samples taken shortly after rising clock edges. It returns high on a rising edge.
- R5: On a read, `ad_oe` is high and `ad_o` carries the addressed half from the sample at which `ready_o` returns high until `rd_n` rises.
- R6: `ad_oe` is low whenever `rd_n` is high or `cs_n` is high, during the wait, and throughout a write.
- R7: Write data is taken from `ad_i` at the first falling clock edge after `wr_n` goes low. Values driven on `ad_i` later are ignored. The data is committed when the wait ends and only to the selected half. The other half of the register keeps its value.
- R8: While `cs_n` is high, the strobes are ignored: `ready_o` stays high, no data is driven and no register changes.
- R9: A register index of `NUM_REGS` or above is outside the bank. Writes to it are dropped and reads from it return zero.
- R10: Reset sets every register to zero, sets `ready_o` high and sets `ad_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address strobe, active high; the address is kept when it falls |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_i | input | 16 | Shared address/data lines, as seen by the block |
| ad_o | output | 16 | Read data driven toward the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ready_o | output | 1 | Ready; low holds the host in a wait state |

## Verification
A vector table runs the main path with four kinds of pattern:
- Writes to the low half and then the high half of the same register, read back separately. These separate the half selection from any whole-word write.
- Accesses to the last register inside the bank and to the first two indexes beyond it. These separate range checking from index wrap-around.
- A read whose address has the upper line bits set. This tells whether those bits are ignored.
- A write whose data lines change after the first falling edge. This shows whether the data is taken early or late.

On every access the bench samples ready just before the first falling edge, then counts the low samples, and checks the output enable during the wait, at release and after the strobe rises. Directed tests drive strobes with chip select high and apply a second reset.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [1:0] {
      MBS_IDLE = 2'd0,
      MBS_WAIT = 2'd1,
      MBS_REL  = 2'd2
   } mbs_state_e;
endpackage

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);
   // The value sampled at the last falling edge with ale high is kept once ale falls.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (ale)
         addr_q <= addr_in;
   end
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
   import mbs_pkg::*;
#(
   parameter int WAIT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic start,
   output logic commit,
   output logic busy,
   output logic rel,
   output logic is_wr
);
   localparam int CNT_W = $clog2(WAIT_CYCLES + 1) + 1;

   mbs_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             done_wait;

   assign start     = (state == MBS_IDLE) && !cs_n && (!rd_n || !wr_n);
   assign done_wait = (state == MBS_WAIT) && (cnt == CNT_W'(WAIT_CYCLES));
   assign commit    = done_wait && is_wr;
   assign busy      = (state != MBS_IDLE);

   // Strobes are sampled on the falling bus-clock edge.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= MBS_IDLE;
         cnt   <= '0;
         is_wr <= 1'b0;
      end else begin
         unique case (state)
            MBS_IDLE: if (start) begin
               state <= MBS_WAIT;
               cnt   <= CNT_W'(1);
               is_wr <= !wr_n;
            end
            MBS_WAIT: if (done_wait) state <= MBS_REL;
                      else           cnt   <= cnt + CNT_W'(1);
            MBS_REL:  if (cs_n || (rd_n && wr_n)) state <= MBS_IDLE;
            default:  state <= MBS_IDLE;
         endcase
      end
   end

   // The release is taken on the rising edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rel <= 1'b0;
      else        rel <= (state == MBS_REL);
   end
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 64,
   parameter int IDX_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_hi,
   output logic [DATA_W-1:0] rd_data
);
   localparam int SEL_W = $clog2(NUM_REGS);

   logic                   wr_ok, rd_ok;
   logic [SEL_W-1:0]       wr_sel, rd_sel;
   logic [1:0][DATA_W-1:0] half_rd;

   assign wr_ok  = wr_en && (int'(wr_idx) < NUM_REGS);
   assign rd_ok  = (int'(rd_idx) < NUM_REGS);
   assign wr_sel = wr_idx[SEL_W-1:0];
   assign rd_sel = rd_idx[SEL_W-1:0];

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DATA_W-1:0] lane [NUM_REGS];
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) lane[i] <= '0;
         end else if (wr_ok && (wr_hi == 1'(h))) begin
            lane[wr_sel] <= wr_data;
         end
      end
      assign half_rd[h] = rd_ok ? lane[rd_sel] : '0;
   end

   assign rd_data = rd_hi ? half_rd[1] : half_rd[0];
endmodule

// File: rtl/mbs_slave.sv
module mbs_slave #(
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 11,
   parameter int NUM_REGS    = 64,
   parameter int WAIT_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             ale,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [BUS_W-1:0] ad_i,
   output logic [BUS_W-1:0] ad_o,
   output logic             ad_oe,
   output logic             ready_o
);
   localparam int IDX_W = ADDR_W - 2;

   if (WAIT_CYCLES < 1)                   begin : g_bad_wait  $error("WAIT_CYCLES must be at least 1"); end
   if (ADDR_W < 3 || ADDR_W >= BUS_W)     begin : g_bad_addr  $error("ADDR_W must be within 3..BUS_W-1"); end
   if (NUM_REGS < 2 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs $error("NUM_REGS out of range"); end

   logic [ADDR_W-1:0] addr_q;
   logic [BUS_W-1:0]  hold_q;
   logic              start, commit, busy, rel, is_wr;
   logic [BUS_W-1:0]  rd_data;
   logic              unused_bits;

   assign unused_bits = ^{ad_i[BUS_W-1:ADDR_W], addr_q[0]};

   mbs_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .ale(ale),
      .addr_in(ad_i[ADDR_W-1:0]), .addr_q(addr_q)
   );

   mbs_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .start(start), .commit(commit), .busy(busy), .rel(rel), .is_wr(is_wr)
   );

   // The write data is held from the first falling edge of the access.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)                hold_q <= '0;
      else if (start && !wr_n)   hold_q <= ad_i;
   end

   mbs_regfile #(.DATA_W(BUS_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit), .wr_idx(addr_q[ADDR_W-1:2]), .wr_hi(addr_q[1]), .wr_data(hold_q),
      .rd_idx(addr_q[ADDR_W-1:2]), .rd_hi(addr_q[1]), .rd_data(rd_data)
   );

   assign ad_o    = rd_data;
   assign ad_oe   = rel && !is_wr && !rd_n && !cs_n;
   assign ready_o = cs_n ? 1'b1 : (!busy || rel);
endmodule

// File: rtl/mbs_slave_chk.sv
module mbs_slave_chk #(
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 11,
   parameter int WAIT_CYCLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rd_n,
   input logic              ale,
   input logic              ready_o,
   input logic              ad_oe,
   input logic              busy,
   input logic [BUS_W-1:0]  hold_q,
   input logic [ADDR_W-1:0] addr_q
);
   logic [7:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lowcnt <= '0;
      else if (ready_o)      lowcnt <= '0;
      else if (lowcnt != 8'hFF) lowcnt <= lowcnt + 8'd1;
   end

   AST_READY_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !ready_o |-> !cs_n);   // R8
   AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !cs_n && lowcnt != 8'd0) |-> (lowcnt == 8'(WAIT_CYCLES + 1)));                  // R4
   AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rd_n && !cs_n && ready_o));                                                      // R6
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(hold_q)));                                                        // R7
   AST_ADDR_ONLY_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(addr_q) |-> ale);                                                                   // R1
endmodule

bind mbs_slave mbs_slave_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ale(ale), .ready_o(ready_o),
   .ad_oe(ad_oe), .busy(busy), .hold_q(hold_q), .addr_q(addr_q)
);

// File: tb/tb_mbs_slave.sv
module tb_mbs_slave;
   localparam int W = 2;
   localparam int NV = 15;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [15:0] ad_i = '0;
   logic [15:0] ad_o;
   logic ad_oe, ready_o;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   mbs_slave #(.WAIT_CYCLES(W)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
      .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .ready_o(ready_o)
   );

   // {write, address, data, expected}
   localparam logic [48:0] VEC [NV] = '{
      {1'b1, 16'h0004, 16'h1234, 16'h0000},
      {1'b1, 16'h0006, 16'hABCD, 16'h0000},
      {1'b0, 16'h0004, 16'h0000, 16'h1234},
      {1'b0, 16'h0006, 16'h0000, 16'hABCD},
      {1'b1, 16'h00FC, 16'h5A5A, 16'h0000},
      {1'b0, 16'h00FC, 16'h0000, 16'h5A5A},
      {1'b0, 16'h00FE, 16'h0000, 16'h0000},
      {1'b1, 16'h0100, 16'hFFFF, 16'h0000},
      {1'b0, 16'h0100, 16'h0000, 16'h0000},
      {1'b0, 16'h0000, 16'h0000, 16'h0000},
      {1'b1, 16'h0004, 16'h0001, 16'h0000},
      {1'b0, 16'h0006, 16'h0000, 16'hABCD},
      {1'b0, 16'h0004, 16'h0000, 16'h0001},
      {1'b0, 16'hF804, 16'h0000, 16'h0001},
      {1'b0, 16'h0105, 16'h0000, 16'h0000}
   };

   function automatic string vec_tag(int i);
      case (i)
         2, 3:    return "R2";
         5:       return "R5";
         6, 11:   return "R7";
         8, 14:   return "R9";
         9:       return "R10";
         12:      return "R7";
         13:      return "R1";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   logic [15:0] rd_val;
   int          lows;
   logic        early_hi, oe_wait, oe_rel, oe_after;

   task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d);
      int guard;
      @(posedge clk); #1 cs_n = 1'b0; ale = 1'b1; ad_i = a;
      @(posedge clk); #1 ale = 1'b0;
      if (wr) begin ad_i = d; wr_n = 1'b0; end
      else    begin ad_i = 16'h0; rd_n = 1'b0; end
      #1 early_hi = ready_o;
      lows = 0; oe_wait = 1'b0; guard = 0;
      forever begin
         @(posedge clk); #2;
         if (wr) ad_i = 16'hDEAD;
         if (ready_o) break;
         lows++;
         if (ad_oe) oe_wait = 1'b1;
         guard++;
         if (guard > 64) break;
      end
      rd_val = ad_o; oe_rel = ad_oe;
      #1 rd_n = 1'b1; wr_n = 1'b1; ad_i = 16'h0;
      #1 oe_after = ad_oe;
      @(posedge clk); #1 cs_n = 1'b1;
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R10: state during reset
      #20;
      chk("R10", {31'd0, ready_o}, 32'd1);
      chk("R10", {31'd0, ad_oe}, 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][48], VEC[i][47:32], VEC[i][31:16]);
         chk("R3", {31'd0, early_hi}, 32'd1);
         chk("R4", lows, W);
         chk("R6", {31'd0, oe_wait}, 32'd0);
         chk("R6", {31'd0, oe_after}, 32'd0);
         if (VEC[i][48]) begin
            chk("R6", {31'd0, oe_rel}, 32'd0);
         end else begin
            chk("R5", {31'd0, oe_rel}, 32'd1);
            chk(vec_tag(i), {16'd0, rd_val}, {16'd0, VEC[i][15:0]});
         end
      end

      // R8: strobes with chip select high
      @(posedge clk); #1 ale = 1'b1; ad_i = 16'h0004;
      @(posedge clk); #1 ale = 1'b0; ad_i = 16'h7777; wr_n = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #2;
         chk("R8", {31'd0, ready_o}, 32'd1);
      end
      #1 wr_n = 1'b1; rd_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #2;
         chk("R8", {30'd0, ready_o, ad_oe}, 32'd2);
      end
      #1 rd_n = 1'b1;
      access(1'b0, 16'h0004, 16'h0);
      chk("R8", {16'd0, rd_val}, 32'h0001);

      // R10: second reset clears the bank
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      access(1'b0, 16'h0006, 16'h0);
      chk("R10", {16'd0, rd_val}, 32'h0000);

      finish_run();
   end
endmodule